// File: doc/BRIEF.md
# CAS Latency Negotiator

This block settles on one CAS latency for a memory controller with two module slots, working from the timing bytes each module advertises. Each slot provides three bytes: a bitmap of the CAS latencies it supports, the minimum cycle time for a latency half a step below its slowest setting, and the minimum cycle time for a full step below. A cycle time becomes a frequency. The block compares that frequency with the controller's link clock to decide how far each slot's bitmap may be extended towards faster settings. It then combines the two trimmed bitmaps and turns the fastest common setting into a 3-bit controller code.

Software or a sequencer presents the bytes and the link clock in MHz on parallel inputs and pulses `start`. The block captures everything on that pulse. It runs the cycle-time checks one after another through a single shared divider. When it finishes it pulses `done` for one cycle. At that point `cas_code` is valid, or `incompat` reports that the two populated slots have no setting in common. Both outputs hold until the next result.

Top module: `cas_negotiator`

## Requirements
- R1: A slot whose bitmap input is 8'hFF is empty and adds a zero bitmap. When both slots are empty, the result is `cas_code` 0 with `incompat` 0.
- R2: A nonzero cycle-time byte with whole nanoseconds in bits [7:4] and tenths in bits [3:0] gives the frequency 20000 / (10*whole + tenths) MHz, using integer division. The byte passes when that frequency is greater than or equal to the link clock.
- R3: A slot's shift is 0 by default. It becomes 1 when the half-step byte is nonzero and passes. Only in that case is the full-step byte examined, and the shift becomes 2 when the full-step byte is also nonzero and passes.
- R4: Trimming keeps the bitmap bits at or above (index of the highest set bit − shift) and clears the rest. When that difference would be negative, every bit is kept.
- R5: When one trimmed bitmap is zero, the other is used alone. Otherwise the two trimmed bitmaps are ANDed.
- R6: The lowest set bit of the combined bitmap selects the code: bit 0 gives 5, bit 1 gives 5, bit 2 gives 2, bit 3 gives 6, and bits 4 to 7 give 0. A zero combined bitmap gives code 0.
- R7: When both trimmed bitmaps are nonzero and their AND is zero, `incompat` is 1 and `cas_code` is 0.
- R8: Each accepted `start` produces exactly one `done` pulse, one cycle wide. With default parameters it arrives no more than 72 cycles after the start edge.
- R9: `start` pulses and input changes that occur while a negotiation is running have no effect on that result and produce no extra `done`.
- R10: After reset, `done`, `cas_code` and `incompat` are 0. `cas_code` and `incompat` change only in the cycle in which `done` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a negotiation and captures all data inputs |
| slot0_map | input | 8 | Slot 0 supported-latency bitmap, 8'hFF for empty |
| slot0_half | input | 8 | Slot 0 cycle time one half step faster |
| slot0_full | input | 8 | Slot 0 cycle time one full step faster |
| slot1_map | input | 8 | Slot 1 supported-latency bitmap, 8'hFF for empty |
| slot1_half | input | 8 | Slot 1 cycle time one half step faster |
| slot1_full | input | 8 | Slot 1 cycle time one full step faster |
| link_mhz | input | 16 | Link clock in MHz |
| cas_code | output | 3 | Selected latency code |
| done | output | 1 | One-cycle result strobe |
| incompat | output | 1 | The populated slots share no latency |

## Verification
The bench goes after boundary cases that have a single plausible bug behind them. When the link clock exactly equals the derived frequency, the byte must pass; a design using a strict compare would return a slower code. A failed half-step check must stop the full-step check from running; a design that evaluated the two independently would widen the bitmap and report a faster code. A slot whose highest bit sits below the shift must keep every bit rather than wrap its mask, and a populated slot with a zero bitmap must defer to the other slot instead of forcing an error. The bench also fires a second start and new inputs in the middle of a run. It expects the first result and only one strobe, which catches a design that re-latches while busy.

// File: rtl/cas_neg_pkg.sv
package cas_neg_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SETUP,
      ST_WAIT,
      ST_FIN
   } neg_state_t;

   localparam int CODE_W = 3;

   // Controller code for the lowest common latency bit.
   function automatic logic [CODE_W-1:0] code_of(input int idx);
      case (idx)
         0, 1:    code_of = CODE_W'(5);
         2:       code_of = CODE_W'(2);
         3:       code_of = CODE_W'(6);
         default: code_of = '0;
      endcase
   endfunction

endpackage

// File: rtl/cas_neg_divider.sv
module cas_neg_divider #(
   parameter int NUMER = 20000,
   parameter int DVW   = 9
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             go,
   input  logic [DVW-1:0]                   divisor,
   output logic                             valid,
   output logic [$clog2(NUMER+1)-1:0]       quot
);
   localparam int QW  = $clog2(NUMER + 1);
   localparam int CNW = $clog2(QW + 1);

   logic [DVW-1:0] rem_q;
   logic [DVW-1:0] dvs_q;
   logic [QW-1:0]  q_q;
   logic [CNW-1:0] cnt_q;
   logic           run_q;
   logic [DVW:0]   trial;

   assign trial = {rem_q, q_q[QW-1]};
   assign quot  = q_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         dvs_q <= '0;
         q_q   <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         valid <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (go) begin
            rem_q <= '0;
            dvs_q <= divisor;
            q_q   <= QW'(NUMER);
            cnt_q <= CNW'(QW);
            run_q <= 1'b1;
         end else if (run_q) begin
            if (trial >= {1'b0, dvs_q}) begin
               rem_q <= DVW'(trial - {1'b0, dvs_q});
               q_q   <= {q_q[QW-2:0], 1'b1};
            end else begin
               rem_q <= trial[DVW-1:0];
               q_q   <= {q_q[QW-2:0], 1'b0};
            end
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNW'(1)) begin
               run_q <= 1'b0;
               valid <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/cas_neg_trim.sv
module cas_neg_trim #(
   parameter int MAP_W = 8
) (
   input  logic [MAP_W-1:0] map_i,
   input  logic             empty_i,
   input  logic [1:0]       shift_i,
   output logic [MAP_W-1:0] map_o
);
   int               hi_idx;
   int               floor_idx;
   logic [MAP_W-1:0] keep;

   always_comb begin
      hi_idx = 0;
      for (int i = 0; i < MAP_W; i++) begin
         if (map_i[i]) hi_idx = i;
      end
      floor_idx = (hi_idx > int'(shift_i)) ? hi_idx - int'(shift_i) : 0;
      for (int i = 0; i < MAP_W; i++) begin
         keep[i] = (i >= floor_idx);
      end
      map_o = empty_i ? '0 : (map_i & keep);
   end
endmodule

// File: rtl/cas_neg_select.sv
module cas_neg_select
   import cas_neg_pkg::*;
#(
   parameter int MAP_W = 8
) (
   input  logic [MAP_W-1:0]  map_a,
   input  logic [MAP_W-1:0]  map_b,
   output logic [CODE_W-1:0] code,
   output logic              clash
);
   logic [MAP_W-1:0] merged;
   int               low_idx;

   always_comb begin
      if (map_a == '0)      merged = map_b;
      else if (map_b == '0) merged = map_a;
      else                  merged = map_a & map_b;
      clash = (map_a != '0) && (map_b != '0) && ((map_a & map_b) == '0);
      low_idx = 0;
      for (int i = MAP_W - 1; i >= 0; i--) begin
         if (merged[i]) low_idx = i;
      end
      code = (merged == '0 || clash) ? '0 : code_of(low_idx);
   end
endmodule

// File: rtl/cas_negotiator.sv
module cas_negotiator
   import cas_neg_pkg::*;
#(
   parameter int MAP_W  = 8,
   parameter int CT_W   = 8,
   parameter int LINK_W = 16,
   parameter int NUMER  = 20000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [MAP_W-1:0]  slot0_map,
   input  logic [CT_W-1:0]   slot0_half,
   input  logic [CT_W-1:0]   slot0_full,
   input  logic [MAP_W-1:0]  slot1_map,
   input  logic [CT_W-1:0]   slot1_half,
   input  logic [CT_W-1:0]   slot1_full,
   input  logic [LINK_W-1:0] link_mhz,
   output logic [2:0]        cas_code,
   output logic              done,
   output logic              incompat
);
   localparam int NSLOT   = 2;
   localparam int NIB     = CT_W / 2;
   localparam int DVW     = CT_W + 1;
   localparam int QW      = $clog2(NUMER + 1);
   localparam int CW      = (QW > LINK_W) ? QW : LINK_W;
   localparam int LAT_MAX = 4 * (QW + 2) + 4;

   generate
      if (MAP_W < 2)        begin : g_bad_map  $error("MAP_W too small");  end
      if (CT_W % 2 != 0)    begin : g_bad_ct   $error("CT_W must be even"); end
      if (NUMER < 2)        begin : g_bad_num  $error("NUMER too small");  end
      if (CODE_W != 3)      begin : g_bad_code $error("code width");       end
   endgenerate

   neg_state_t                   st_q;
   logic [NSLOT-1:0][MAP_W-1:0]  map_q;
   logic [NSLOT-1:0][CT_W-1:0]   half_q;
   logic [NSLOT-1:0][CT_W-1:0]   full_q;
   logic [NSLOT-1:0][1:0]        shift_q;
   logic [NSLOT-1:0][MAP_W-1:0]  trimmed;
   logic [NSLOT-1:0]             empty;
   logic [LINK_W-1:0]            link_q;
   logic                         sel_q;
   logic                         step_q;
   logic [CT_W-1:0]              cur_byte;
   logic [DVW-1:0]               denom;
   logic                         skip;
   logic                         div_go;
   logic                         div_valid;
   logic [QW-1:0]                div_q;
   logic                         pass;
   logic [CODE_W-1:0]            sel_code;
   logic                         sel_clash;
   logic                         busy;

   assign busy     = (st_q != ST_IDLE);
   assign cur_byte = step_q ? full_q[sel_q] : half_q[sel_q];
   assign denom    = DVW'(cur_byte[CT_W-1:NIB]) * DVW'(10) + DVW'(cur_byte[NIB-1:0]);
   assign skip     = empty[sel_q] || (cur_byte == '0);
   assign div_go   = (st_q == ST_SETUP) && !skip;
   assign pass     = (CW'(div_q) >= CW'(link_q));

   generate
      for (genvar s = 0; s < NSLOT; s++) begin : g_slot
         assign empty[s] = (map_q[s] == '1);
         cas_neg_trim #(.MAP_W(MAP_W)) u_trim (
            .map_i   (map_q[s]),
            .empty_i (empty[s]),
            .shift_i (shift_q[s]),
            .map_o   (trimmed[s])
         );
      end
   endgenerate

   cas_neg_divider #(.NUMER(NUMER), .DVW(DVW)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (div_go),
      .divisor (denom),
      .valid   (div_valid),
      .quot    (div_q)
   );

   cas_neg_select #(.MAP_W(MAP_W)) u_sel (
      .map_a (trimmed[0]),
      .map_b (trimmed[1]),
      .code  (sel_code),
      .clash (sel_clash)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         map_q    <= '0;
         half_q   <= '0;
         full_q   <= '0;
         shift_q  <= '0;
         link_q   <= '0;
         sel_q    <= 1'b0;
         step_q   <= 1'b0;
         cas_code <= '0;
         incompat <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  map_q   <= {slot1_map, slot0_map};
                  half_q  <= {slot1_half, slot0_half};
                  full_q  <= {slot1_full, slot0_full};
                  link_q  <= link_mhz;
                  shift_q <= '0;
                  sel_q   <= 1'b0;
                  step_q  <= 1'b0;
                  st_q    <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               if (!skip) begin
                  st_q <= ST_WAIT;
               end else if (sel_q) begin
                  st_q <= ST_FIN;
               end else begin
                  sel_q  <= 1'b1;
                  step_q <= 1'b0;
               end
            end
            ST_WAIT: begin
               if (div_valid) begin
                  if (pass) shift_q[sel_q] <= step_q ? 2'd2 : 2'd1;
                  if (pass && !step_q) begin
                     step_q <= 1'b1;
                     st_q   <= ST_SETUP;
                  end else if (sel_q) begin
                     st_q <= ST_FIN;
                  end else begin
                     sel_q  <= 1'b1;
                     step_q <= 1'b0;
                     st_q   <= ST_SETUP;
                  end
               end
            end
            ST_FIN: begin
               cas_code <= sel_code;
               incompat <= sel_clash;
               done     <= 1'b1;
               st_q     <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cas_negotiator_chk.sv
module cas_negotiator_chk #(
   parameter int LAT_MAX = 72
) (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       done,
   input logic       incompat,
   input logic [2:0] cas_code
);
   int lat_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lat_cnt <= 0;
      else if (!busy) lat_cnt <= 0;
      else            lat_cnt <= lat_cnt + 1;
   end

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_from_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));

   p_latency_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (lat_cnt < LAT_MAX));

   p_clash_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      incompat |-> (cas_code == 3'd0));

   p_code_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_code == 3'd0) || (cas_code == 3'd2) || (cas_code == 3'd5) || (cas_code == 3'd6));

   p_hold_outputs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(cas_code) && $stable(incompat)));
endmodule

bind cas_negotiator cas_negotiator_chk #(.LAT_MAX(LAT_MAX)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .incompat (incompat),
   .cas_code (cas_code)
);

// File: tb/cas_negotiator_bench.sv
`timescale 1ns/1ps
module cas_negotiator_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  m0 = 8'hFF, h0 = '0, f0 = '0, m1 = 8'hFF, h1 = '0, f1 = '0;
   logic [15:0] link = 16'd100;
   logic [2:0]  cas_code;
   logic        done;
   logic        incompat;

   int   checks = 0;
   int   errors = 0;
   int   cyc = 0;
   int   start_cyc = 0;
   int   done_cyc = 0;
   bit   pending = 0;
   bit   got_done = 0;
   logic [2:0] cap_code = '0;
   logic       cap_err = 1'b0;
   logic [2:0] prev_code = '0;
   logic       prev_err = 1'b0;
   logic [31:0] lf = 32'h1BADF00D;

   localparam int LAT_LIMIT = 72;

   always #2 clk = ~clk;

   cas_negotiator u_cas_negotiator (
      .clk(clk), .rst_n(rst_n), .start(start),
      .slot0_map(m0), .slot0_half(h0), .slot0_full(f0),
      .slot1_map(m1), .slot1_half(h1), .slot1_full(f1),
      .link_mhz(link), .cas_code(cas_code), .done(done), .incompat(incompat)
   );

   task automatic summary_and_end();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog R8 actual=hung expected=finish");
         summary_and_end();
      end
   end

   // Per-clock monitor: strobes only for pending runs, outputs hold otherwise.
   always @(negedge clk) begin
      if (rst_n) begin
         checks = checks + 1;
         if (done) begin
            if (!pending) begin
               errors = errors + 1;
               $display("FAIL R8/R9 stray done actual=1 expected=0");
            end else begin
               pending  = 0;
               got_done = 1;
               cap_code = cas_code;
               cap_err  = incompat;
               done_cyc = cyc;
            end
         end else if (cas_code !== prev_code || incompat !== prev_err) begin
            errors = errors + 1;
            $display("FAIL R10 outputs moved without done actual=%0d/%0d expected=%0d/%0d",
                     cas_code, incompat, prev_code, prev_err);
         end
         prev_code = cas_code;
         prev_err  = incompat;
      end
   end

   function automatic int freq_of(input int b);
      return 20000 / (((b >> 4) & 15) * 10 + (b & 15));
   endfunction

   function automatic int trim_ref(input int map, input int hb, input int fb, input int lk);
      int sh = 0;
      int hi = 0;
      int fl;
      if (map == 255) return 0;
      if (hb != 0 && freq_of(hb) >= lk) begin
         sh = 1;
         if (fb != 0 && freq_of(fb) >= lk) sh = 2;
      end
      if (map == 0) return 0;
      for (int i = 0; i < 8; i++) if ((map >> i) & 1) hi = i;
      fl = (hi - sh < 0) ? 0 : hi - sh;
      return map & ~((1 << fl) - 1) & 255;
   endfunction

   task automatic ref_model(output int code, output bit err);
      int a = trim_ref(m0, h0, f0, link);
      int b = trim_ref(m1, h1, f1, link);
      int c;
      int low = 99;
      int tbl[5] = '{5, 5, 2, 6, 0};
      err = 0;
      if (a == 0) c = b;
      else if (b == 0) c = a;
      else begin
         c = a & b;
         if (c == 0) err = 1;
      end
      for (int i = 7; i >= 0; i--) if ((c >> i) & 1) low = i;
      code = (c == 0) ? 0 : ((low < 5) ? tbl[low] : 0);
   endtask

   task automatic wait_result(input string tag);
      int n = 0;
      while (!got_done && n < 200) begin
         @(posedge clk);
         n++;
      end
      checks = checks + 1;
      if (!got_done) begin
         errors = errors + 1;
         $display("FAIL %s R8 no done actual=0 expected=1", tag);
      end else begin
         checks = checks + 1;
         if (done_cyc - start_cyc > LAT_LIMIT) begin
            errors = errors + 1;
            $display("FAIL %s R8 latency actual=%0d expected<=%0d", tag,
                     done_cyc - start_cyc, LAT_LIMIT);
         end
      end
   endtask

   task automatic launch(input logic [7:0] a, b, c, d, e, f, input logic [15:0] l);
      @(negedge clk);
      m0 = a; h0 = b; f0 = c; m1 = d; h1 = e; f1 = f; link = l;
      start = 1'b1;
      pending = 1;
      got_done = 0;
      start_cyc = cyc;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic compare(input int ec, input bit ee, input string tag);
      checks = checks + 1;
      if (cap_code !== 3'(ec) || cap_err !== ee) begin
         errors = errors + 1;
         $display("FAIL %s actual=%0d/%0d expected=%0d/%0d", tag, cap_code, cap_err, ec, ee);
      end
   endtask

   task automatic run(input logic [7:0] a, b, c, d, e, f, input logic [15:0] l,
                      input int ec, input bit ee, input string tag);
      int rc;
      bit re;
      launch(a, b, c, d, e, f, l);
      wait_result(tag);
      compare(ec, ee, tag);
      ref_model(rc, re);
      checks = checks + 1;
      if (rc != ec || re != ee) begin
         errors = errors + 1;
         $display("FAIL %s model mismatch actual=%0d/%0d expected=%0d/%0d", tag, rc, re, ec, ee);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks = checks + 1;
      if (done !== 1'b0 || cas_code !== 3'd0 || incompat !== 1'b0) begin
         errors = errors + 1;
         $display("FAIL R10 reset actual=%0d/%0d/%0d expected=0/0/0", done, cas_code, incompat);
      end

      run(8'hFF, 8'h75, 8'hA0, 8'hFF, 8'h50, 8'h40, 16'd100, 0, 0, "R1 both empty");
      run(8'h1C, 8'h75, 8'hA0, 8'hFF, 8'h00, 8'h00, 16'd200, 2, 0, "R2 equal freq passes");
      run(8'h1C, 8'h75, 8'hA0, 8'hFF, 8'h00, 8'h00, 16'd201, 6, 0, "R2 one above fails");
      run(8'h0C, 8'h00, 8'hA0, 8'hFF, 8'h00, 8'h00, 16'd100, 6, 0, "R3 zero half byte");
      run(8'h0C, 8'h75, 8'h10, 8'hFF, 8'h00, 8'h00, 16'd300, 6, 0, "R3 half fails full skipped");
      run(8'h03, 8'h50, 8'h40, 8'hFF, 8'h00, 8'h00, 16'd100, 5, 0, "R4 clamp below zero");
      run(8'hE0, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 16'd100, 0, 0, "R6 high bit gives 0");
      run(8'h08, 8'h00, 8'h00, 8'h04, 8'h00, 8'h00, 16'd100, 0, 1, "R7 no common bit");
      run(8'h0C, 8'h50, 8'h40, 8'h08, 8'h00, 8'h00, 16'd100, 6, 0, "R5 intersection");
      run(8'hFF, 8'h00, 8'h00, 8'h1C, 8'h75, 8'hA0, 16'd201, 6, 0, "R1 slot1 alone");
      run(8'h00, 8'h50, 8'h40, 8'h04, 8'h00, 8'h00, 16'd100, 2, 0, "R5 zero map defers");
      run(8'h06, 8'h50, 8'h40, 8'hFF, 8'h00, 8'h00, 16'd100, 5, 0, "R6 bit1 gives 5");

      // R9: restart and new inputs mid-run are ignored.
      launch(8'h1C, 8'h75, 8'hA0, 8'hFF, 8'h00, 8'h00, 16'd200);
      repeat (5) @(negedge clk);
      m0 = 8'h08; h0 = 8'h00; m1 = 8'h04; link = 16'd900;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_result("R9 busy restart");
      compare(2, 0, "R9 first result kept");
      got_done = 0;
      repeat (100) @(negedge clk);
      checks = checks + 1;
      if (got_done) begin
         errors = errors + 1;
         $display("FAIL R9 second done actual=1 expected=0");
      end

      for (int k = 0; k < 40; k++) begin
         int rc;
         bit re;
         logic [7:0] a, b, c, d, e, f;
         logic [15:0] l;
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         a = (lf[2:0] == 3'd0) ? 8'hFF : lf[10:3];
         b = lf[4] ? lf[18:11] : 8'h00;
         c = lf[19:12];
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         lf = lf * 32'd1103515245 + 32'd12345;
         d = (lf[2:0] == 3'd1) ? 8'hFF : lf[12:5];
         e = lf[3] ? lf[20:13] : 8'h00;
         f = lf[28:21];
         l = 16'd150 + 16'(lf[30:22]);
         launch(a, b, c, d, e, f, l);
         wait_result("R5 sweep");
         ref_model(rc, re);
         compare(rc, re, "R5/R6/R7 sweep");
      end

      repeat (4) @(negedge clk);
      summary_and_end();
   end
endmodule